// File: doc/BRIEF.md
# Serial Character Transmitter with Handshake Control

This block turns bytes into an asynchronous serial stream. A byte written while the transmitter is enabled lands in a one-entry holding register. At the next bit-rate tick the byte moves into a shift register, and the line then carries a low start bit, the data bits with the least significant bit first, and a high stop bit. Each bit lasts exactly one tick period. A byte waiting in the holding register follows the previous stop bit with no idle bit in between.

The block supports modem-style flow control. With the clear-to-send gate enabled, a character starts only while `cts` is high. The gate is sampled only at character boundaries, so a character already on the line always finishes. A start-break command holds the line low regardless of `cts` until a stop-break command arrives. After that the line idles high for at least one full bit period. The request-to-send output is raised by a command. In automatic mode it drops one bit period after the last stop bit, once the transmitter has been disabled.

A disable command stops new writes, but everything already accepted is still sent. A software reset aborts at once: the line returns high mid-character, the holding register is emptied and the transmitter is disabled. The baud divider, receiver and register decode sit outside this block.

Top module: `uart_tx_flow`

## Requirements
- R1: After `rst_n` is released, `txd` = 1, `rts` = 0, `tx_rdy` = 1 and `tx_emp` = 1.
- R2: A character is 10 bit periods, each starting at a clock edge where `baud_tick` = 1. The periods are, in order: start (0), data bit 0 through data bit 7, stop (1). Apart from the command cases in R7, R10 and R11, `txd` changes only at tick edges.
- R3: `tx_emp` is 1 exactly when both the holding register and the shift register are empty. It goes to 0 on the clock after a write is accepted.
- R4: `tx_rdy` is 0 while the holding register holds a byte. It returns to 1 in the clock where the start bit of that byte appears.
- R5: A write is accepted only while the transmitter is enabled and `tx_rdy` = 1. Any other write is ignored and leaves no trace on `txd`, `tx_rdy` or `tx_emp`.
- R6: After `cmd_disable`, the byte in the shift register and any byte in the holding register are still sent in full, and then the line stays idle.
- R7: On the clock after `cmd_reset`, `txd` = 1, `tx_emp` = 1 and `tx_rdy` = 1, even in mid-character. The transmitter is then disabled.
- R8: With `cts_gate_en` = 1, a start bit is emitted only at a tick where `cts` was 1.
- R9: If `cts` falls during a character, that character finishes with its stop bit. `txd` then stays 1 until `cts` returns to 1.
- R10: `cmd_brk_start` forces `txd` to 0 continuously, whatever the value of `cts`. This takes effect on the next clock when the shifter is idle, or right after the stop bit of a character in progress.
- R11: After `cmd_brk_stop`, `txd` is 1 for at least one full bit period (4 clocks in the bench) before the next start bit.
- R12: `cmd_rts_set` drives `rts` to 1. With `auto_rts_en` = 1 and the transmitter disabled, `rts` falls at the second tick after the last stop bit began, that is one bit period after the stop bit ends. With `auto_rts_en` = 0, `rts` never falls except through `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse per bit period |
| wr_en | input | 1 | Write strobe into the holding register |
| wr_data | input | DATA_W | Byte to send |
| cmd_enable | input | 1 | Enable the transmitter |
| cmd_disable | input | 1 | Graceful disable (wins over enable) |
| cmd_reset | input | 1 | Software reset, aborts immediately |
| cmd_brk_start | input | 1 | Begin a break condition |
| cmd_brk_stop | input | 1 | End a break condition |
| cmd_rts_set | input | 1 | Raise the request-to-send output |
| cts_gate_en | input | 1 | Make character starts depend on `cts` |
| auto_rts_en | input | 1 | Drop `rts` automatically after the final character |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial line, idles high |
| rts | output | 1 | Request-to-send, active high |
| tx_rdy | output | 1 | Holding register can take a byte |
| tx_emp | output | 1 | Holding and shift registers both empty |

## Verification
All 256 byte values are sent back to back. Every frame is compared bit by bit against a frame the bench builds arithmetically, which exposes bit-order, framing and inter-frame gap errors. Other runs hold `cts` low before a start, drop it mid-character, put a break between characters, disable with bytes still queued, and issue a software reset mid-byte. Each of these patterns separates a boundary-sampled gate from a level gate, and a graceful stop from an abort. The automatic request-to-send run samples `rts` one and two bit periods after the last stop bit, which catches a drop that comes one bit early or one bit late.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_BREAK = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_e;

  // number of bit periods per character: start + data + stop
  function automatic int unsigned frame_len(input int unsigned data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (soft_rst) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cts_ok,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              txd,
  output logic              busy,
  output logic              idle,
  output logic              in_break,
  output logic              load
);

  localparam int unsigned FRAME = frame_len(DATA_W);
  localparam int unsigned CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  idx;
  logic              brk_pend;
  logic              txd_q;

  // line level for bit period i of a frame carrying d
  function automatic logic frame_bit(input logic [DATA_W-1:0] d,
                                     input logic [CNT_W-1:0]  i);
    logic [DATA_W-1:0] sh;
    if (i == '0) return 1'b0;
    if (i == LAST) return 1'b1;
    sh = d >> (i - 1'b1);
    return sh[0];
  endfunction

  logic at_last;
  logic slot_free;
  logic want_brk;

  assign at_last   = (state == ST_SEND) && (idx == LAST);
  assign slot_free = (state == ST_IDLE) || at_last;
  assign want_brk  = brk_pend || brk_start;
  assign load      = tick && slot_free && hold_full && cts_ok && !want_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      idx      <= '0;
      brk_pend <= 1'b0;
      txd_q    <= 1'b1;
    end else if (soft_rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      brk_pend <= 1'b0;
      txd_q    <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (brk_start) begin
            state <= ST_BREAK;
            txd_q <= 1'b0;
          end else if (load) begin
            state <= ST_SEND;
            shreg <= hold_data;
            idx   <= '0;
            txd_q <= 1'b0;
          end
        end
        ST_SEND: begin
          if (brk_start)     brk_pend <= 1'b1;
          else if (brk_stop) brk_pend <= 1'b0;
          if (tick) begin
            if (idx == LAST) begin
              if (want_brk && !brk_stop) begin
                state    <= ST_BREAK;
                brk_pend <= 1'b0;
                txd_q    <= 1'b0;
              end else if (load) begin
                shreg <= hold_data;
                idx   <= '0;
                txd_q <= 1'b0;
              end else begin
                state    <= ST_IDLE;
                brk_pend <= 1'b0;
              end
            end else begin
              idx   <= idx + 1'b1;
              txd_q <= frame_bit(shreg, idx + 1'b1);
            end
          end
        end
        ST_BREAK: begin
          txd_q <= 1'b0;
          if (brk_stop) begin
            state <= ST_GAP;
            txd_q <= 1'b1;
          end
        end
        ST_GAP: begin
          txd_q <= 1'b1;
          if (tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txd      = txd_q;
  assign busy     = (state == ST_SEND);
  assign idle     = (state == ST_IDLE);
  assign in_break = (state == ST_BREAK);

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic set_cmd,
  input  logic auto_en,
  input  logic enabled,
  input  logic quiet,
  output logic rts
);

  logic drop_evt;

  assign drop_evt = tick && auto_en && !enabled && quiet && rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rts <= 1'b0;
    else if (set_cmd)  rts <= 1'b1;
    else if (drop_evt) rts <= 1'b0;
  end

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_reset,
  input  logic              cmd_brk_start,
  input  logic              cmd_brk_stop,
  input  logic              cmd_rts_set,
  input  logic              cts_gate_en,
  input  logic              auto_rts_en,
  input  logic              cts,
  output logic              txd,
  output logic              rts,
  output logic              tx_rdy,
  output logic              tx_emp
);

  logic              enabled;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              wr_accept;
  logic              load_evt;
  logic              cts_ok;
  logic              sh_busy;
  logic              sh_idle;
  logic              sh_in_break;
  logic              line_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           enabled <= 1'b0;
    else if (cmd_reset)   enabled <= 1'b0;
    else if (cmd_disable) enabled <= 1'b0;
    else if (cmd_enable)  enabled <= 1'b1;
  end

  assign wr_accept  = wr_en && enabled && !hold_full && !cmd_reset;
  assign cts_ok     = !cts_gate_en || cts;
  assign line_quiet = sh_idle && !hold_full;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (cmd_reset),
    .wr       (wr_accept),
    .wr_data  (wr_data),
    .take     (load_evt),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (cmd_reset),
    .tick      (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cts_ok    (cts_ok),
    .brk_start (cmd_brk_start),
    .brk_stop  (cmd_brk_stop),
    .txd       (txd),
    .busy      (sh_busy),
    .idle      (sh_idle),
    .in_break  (sh_in_break),
    .load      (load_evt)
  );

  uart_tx_rts u_rts (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .set_cmd (cmd_rts_set),
    .auto_en (auto_rts_en),
    .enabled (enabled),
    .quiet   (line_quiet),
    .rts     (rts)
  );

  assign tx_rdy = !hold_full;
  assign tx_emp = !hold_full && !sh_busy;

endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic cmd_reset,
  input logic cmd_brk_start,
  input logic cmd_brk_stop,
  input logic cts_gate_en,
  input logic cts,
  input logic auto_rts_en,
  input logic txd,
  input logic rts,
  input logic tx_rdy,
  input logic tx_emp,
  input logic busy,
  input logic in_break
);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_tick_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(baud_tick) && !$past(cmd_reset) && !$past(cmd_brk_start)
     && !$past(cmd_brk_stop)) |-> $stable(txd));

  p_load_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_rdy);

  p_reset_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (txd && tx_emp && tx_rdy));

  p_start_cts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cts_gate_en || cts));

  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd);

  p_rts_auto_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rts_en && !$past(auto_rts_en)) |-> !$fell(rts));

endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .baud_tick     (baud_tick),
  .cmd_reset     (cmd_reset),
  .cmd_brk_start (cmd_brk_start),
  .cmd_brk_stop  (cmd_brk_stop),
  .cts_gate_en   (cts_gate_en),
  .cts           (cts),
  .auto_rts_en   (auto_rts_en),
  .txd           (txd),
  .rts           (rts),
  .tx_rdy        (tx_rdy),
  .tx_emp        (tx_emp),
  .busy          (sh_busy),
  .in_break      (sh_in_break)
);

// File: tb/tb_uart_tx_flow.sv
`timescale 1ns/1ps
module tb_uart_tx_flow;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
  logic cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0, cmd_rts_set = 1'b0;
  logic cts_gate_en = 1'b0, auto_rts_en = 1'b0, cts = 1'b0;
  logic txd, rts, tx_rdy, tx_emp;

  always #2 clk = ~clk;

  uart_tx_flow #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_reset(cmd_reset), .cmd_brk_start(cmd_brk_start),
    .cmd_brk_stop(cmd_brk_stop), .cmd_rts_set(cmd_rts_set),
    .cts_gate_en(cts_gate_en), .auto_rts_en(auto_rts_en), .cts(cts),
    .txd(txd), .rts(rts), .tx_rdy(tx_rdy), .tx_emp(tx_emp)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;
  int cyc = 0;
  int stop_cyc = 0;
  bit mon_en = 1'b0;
  bit mon_busy = 1'b0;
  logic [8:0] rxq[$];

  always @(posedge clk) cyc <= cyc + 1;

  // bit-rate tick: one clock in every four
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      baud_tick = (rst_n && div == 0);
    end
  end

  // line monitor: start detected at a negedge, then sample mid-bit
  initial begin
    logic [8:0] f;
    forever begin
      @(negedge clk);
      if (mon_en && txd === 1'b0) begin
        mon_busy = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 9; k++) begin
          repeat (4) @(negedge clk);
          f[k] = txd;
        end
        stop_cyc = cyc;
        rxq.push_back(f);
        mon_busy = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_enable = 1'b1;
      1: cmd_disable = 1'b1;
      2: cmd_reset = 1'b1;
      3: cmd_brk_start = 1'b1;
      4: cmd_brk_stop = 1'b1;
      default: cmd_rts_set = 1'b1;
    endcase
    @(negedge clk);
    {cmd_enable, cmd_disable, cmd_reset, cmd_brk_start, cmd_brk_stop, cmd_rts_set} = '0;
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (tx_rdy !== 1'b1 && n < 200) begin @(negedge clk); n++; end
  endtask

  // expected frame built arithmetically: stop bit on top, data below
  task automatic expect_frame(input logic [7:0] exp, input string tag);
    int n = 0;
    logic [8:0] got;
    while (rxq.size() == 0 && n < 400) begin @(negedge clk); n++; end
    if (rxq.size() == 0) begin
      chk(1'b0, tag, 0, 32'h100 + exp);
    end else begin
      got = rxq.pop_front();
      chk(got == (9'h100 | {1'b0, exp}), tag, got, 32'h100 + exp);
    end
  endtask

  task automatic expect_mark(input int n, input string tag);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, tag, lows, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lows;
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1 && rts === 0 && tx_rdy === 1 && tx_emp === 1, "R1 reset",
        {txd, rts, tx_rdy, tx_emp}, 4'b1011);
    mon_en = 1'b1;

    // R5 write while disabled is ignored
    put(8'h5A);
    chk(tx_rdy === 1 && tx_emp === 1, "R5 write while disabled", {tx_rdy, tx_emp}, 2'b11);
    expect_mark(60, "R5 disabled line idle");

    // R2/R3/R4 sweep of every byte value
    pulse(0);
    lows = 0;
    for (int b = 0; b < 256; b++) begin
      wait_rdy();
      put(8'(b));
      if (tx_rdy !== 1'b0 || tx_emp !== 1'b0) lows++;
    end
    chk(lows == 0, "R3 R4 flags after write", lows, 0);
    for (int b = 0; b < 256; b++) expect_frame(8'(b), "R2 frame sweep");
    repeat (12) @(negedge clk);
    chk(tx_emp === 1 && tx_rdy === 1, "R3 empty after drain", {tx_emp, tx_rdy}, 2'b11);

    // R8 gate holds start, R5 second write while full ignored
    cts_gate_en = 1'b1;
    cts = 1'b0;
    put(8'h96);
    put(8'h0F);
    expect_mark(60, "R8 no start while cts low");
    chk(tx_rdy === 0, "R4 holding full", tx_rdy, 0);
    cts = 1'b1;
    expect_frame(8'h96, "R8 start after cts");
    repeat (80) @(negedge clk);
    chk(rxq.size() == 0 && tx_emp === 1, "R5 write while full ignored", rxq.size(), 0);

    // R9 cts drop mid-character
    put(8'h3C);
    wait_rdy();
    put(8'hC3);
    repeat (8) @(negedge clk);
    cts = 1'b0;
    expect_frame(8'h3C, "R9 character completes");
    expect_mark(60, "R9 mark while cts low");
    chk(rxq.size() == 0, "R9 no second frame", rxq.size(), 0);
    cts = 1'b1;
    expect_frame(8'hC3, "R9 resumes after cts");
    repeat (20) @(negedge clk);

    // R10 break ignores cts, R11 mark gap after break
    mon_en = 1'b0;
    cts = 1'b0;
    pulse(3);
    chk(txd === 0, "R10 break starts", txd, 0);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b0) lows++; end
    chk(lows == 0, "R10 break held low with cts low", lows, 0);
    cts_gate_en = 1'b0;
    put(8'hA5);
    pulse(4);
    mon_en = 1'b1;
    gap = 0;
    while (txd === 1'b1 && gap < 100) begin gap++; @(negedge clk); end
    chk(gap >= 4 && gap < 100, "R11 mark after break", gap, 4);
    expect_frame(8'hA5, "R11 frame after break");
    repeat (20) @(negedge clk);

    // R6 graceful disable drains both registers
    put(8'h81);
    wait_rdy();
    put(8'h7E);
    pulse(1);
    expect_frame(8'h81, "R6 shift char completes");
    expect_frame(8'h7E, "R6 holding char completes");
    put(8'hFF);
    repeat (80) @(negedge clk);
    chk(rxq.size() == 0 && tx_emp === 1 && tx_rdy === 1, "R6 disabled stays idle",
        rxq.size(), 0);

    // R12 automatic rts drop timing
    pulse(0);
    auto_rts_en = 1'b1;
    pulse(5);
    chk(rts === 1, "R12 rts set", rts, 1);
    put(8'h44);
    wait_rdy();
    pulse(1);
    expect_frame(8'h44, "R12 frame");
    while (cyc < stop_cyc + 4) @(negedge clk);
    chk(rts === 1, "R12 rts held through first bit after stop", rts, 1);
    while (cyc < stop_cyc + 8) @(negedge clk);
    chk(rts === 0, "R12 rts dropped one bit after stop", rts, 0);
    auto_rts_en = 1'b0;
    pulse(5);
    repeat (40) @(negedge clk);
    chk(rts === 1, "R12 rts kept without auto mode", rts, 1);

    // R7 software reset mid-character
    pulse(0);
    put(8'h00);
    wait_rdy();
    put(8'h11);
    repeat (14) @(negedge clk);
    mon_en = 1'b0;
    pulse(2);
    chk(txd === 1 && tx_emp === 1 && tx_rdy === 1, "R7 abort", {txd, tx_emp, tx_rdy}, 3'b111);
    put(8'h22);
    expect_mark(80, "R7 stays idle and disabled");
    while (mon_busy) @(negedge clk);
    rxq.delete();

    summary();
  end

endmodule